// File: doc/BRIEF.md
# Serial-Link Reset Request Controller

This block sits behind the symbol decoder of one serial port. It watches decoded link control symbols and packet-start strobes and looks for a reset request. A reset request is a run of back-to-back reset-device link requests, and only status symbols may fall between them. When it finds one, a configuration bit chooses the response. The block either runs a timed self reset of the local device, or it latches the request. A latched request holds an active-low software-reset output and a per-port status bit until software clears the status. In latched mode a maskable interrupt can tell a local processor about the request.

The hard-reset input is asynchronous. Its assertion clears all state at once. Its release passes through a two-flop synchroniser before the logic leaves reset. The interrupt output is gated so that it is never high while the device is held in hard reset or in self reset.

Top module: `link_rst_req_ctrl`

## Requirements
- R1: A request is recognised on the fourth reset-device symbol (`sym_valid` high with `sym_type` = 1) of an unbroken run. Three such symbols alone produce no response.
- R2: Status symbols (`sym_type` = 0) that fall between reset-device symbols neither advance nor clear the run.
- R3: Any other symbol code (2 or 3) clears the run to zero. A `pkt_start` pulse also clears it. When `pkt_start` and a symbol come in the same cycle, the packet wins and the symbol is ignored.
- R4: With `cfg_self_rst_en` high, `sw_rst_n` goes low at the clock edge that takes in the fourth symbol. It stays low for exactly SELF_RST_CYCLES cycles (default 6, never below 4) and then returns high. `req_status` stays low throughout, and afterwards the run count starts again from zero.
- R5: With `cfg_self_rst_en` low, a recognised request sets `req_status` and drives `sw_rst_n` low at that same edge. Both hold until a `stat_clr` pulse, after which both return to idle one edge later.
- R6: `irq` is high exactly when `req_status` is high and `cfg_rst_int_en` is high.
- R7: `irq` is never high while hard reset is applied or a self reset is in progress.
- R8: `stat_clr` has no effect during a self reset: the self-reset duration does not change.
- R9: Reset-device symbols that arrive while a request is pending or a self reset is running do not restart or extend any timing, and they do not count toward a later request.
- R10: A low `hard_rst_n` clears `req_status`, `irq` and the run count immediately and drives `sw_rst_n` high. After release, the logic leaves reset on the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| sym_valid | input | 1 | A decoded control symbol is present this cycle |
| sym_type | input | 2 | Symbol code: 0 status, 1 reset-device request, 2/3 other |
| pkt_start | input | 1 | A packet begins this cycle |
| cfg_self_rst_en | input | 1 | 1 selects timed self reset, 0 selects latched request |
| cfg_rst_int_en | input | 1 | Enables the interrupt for a latched request |
| stat_clr | input | 1 | Software pulse that clears the latched request status |
| sw_rst_n | output | 1 | Active-low software-reset output |
| req_status | output | 1 | Latched reset-request status of this port |
| irq | output | 1 | Reset-request interrupt |

## Verification
The detector is driven with clean runs of four reset-device symbols and with runs one symbol short. This shows the count threshold is exact. Runs with status symbols mixed in are set against runs broken by other control codes, by a lone packet strobe, and by a packet strobe that collides with a reset-device symbol. Together these separate the cases where the count is ignored, cleared, or wrongly advanced. Self-reset pulses are measured cycle by cycle, both quiet and while clear strobes and extra reset-device symbols arrive, to show that the duration is fixed. Hard reset is applied mid-request and mid-run to show that state is cleared at once and that a partial run does not survive.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

    typedef enum logic [1:0] {
        SYM_STATUS = 2'd0,
        SYM_RSTDEV = 2'd1,
        SYM_OTHER  = 2'd2,
        SYM_RSVD   = 2'd3
    } sym_kind_e;

    typedef struct packed {
        logic pending;
    } top_state_t;

endpackage

// File: rtl/lrr_rst_sync.sv
module lrr_rst_sync (
    input  logic clk,
    input  logic async_rst_n,
    output logic sync_rst_n
);
    logic [1:0] stage_q;

    always_ff @(posedge clk or negedge async_rst_n) begin
        if (!async_rst_n) begin
            stage_q <= 2'b00;
        end else begin
            stage_q <= {stage_q[0], 1'b1};
        end
    end

    assign sync_rst_n = stage_q[1];
endmodule

// File: rtl/lrr_run_det.sv
module lrr_run_det #(
    parameter int RUN_LEN = 4,
    parameter int CW      = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_clr,
    input  logic          sym_valid,
    input  logic [1:0]    sym_type,
    input  logic          pkt_start,
    output logic          hit,
    output logic [CW-1:0] run_cnt
);
    import lrr_pkg::*;

    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_state_t;

    run_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        hit   = 1'b0;
        if (hold_clr || pkt_start) begin
            nxt_d.cnt = '0;
        end else if (sym_valid) begin
            case (sym_kind_e'(sym_type))
                SYM_STATUS: nxt_d.cnt = cur_q.cnt;
                SYM_RSTDEV: begin
                    if (cur_q.cnt == LAST) begin
                        hit       = 1'b1;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                default:    nxt_d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign run_cnt = cur_q.cnt;
endmodule

// File: rtl/lrr_self_timer.sv
module lrr_self_timer #(
    parameter int CYCLES = 6,
    parameter int TW     = (CYCLES > 2) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam logic [TW-1:0] LOAD = TW'(CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [TW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.active) begin
            if (cur_q.cnt == '0) begin
                nxt_d.active = 1'b0;
            end else begin
                nxt_d.cnt = cur_q.cnt - 1'b1;
            end
        end else if (start) begin
            nxt_d.active = 1'b1;
            nxt_d.cnt    = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign active = cur_q.active;
endmodule

// File: rtl/link_rst_req_ctrl.sv
module link_rst_req_ctrl #(
    parameter int RUN_LEN         = 4,
    parameter int SELF_RST_CYCLES = 6
) (
    input  logic       clk,
    input  logic       hard_rst_n,
    input  logic       sym_valid,
    input  logic [1:0] sym_type,
    input  logic       pkt_start,
    input  logic       cfg_self_rst_en,
    input  logic       cfg_rst_int_en,
    input  logic       stat_clr,
    output logic       sw_rst_n,
    output logic       req_status,
    output logic       irq
);
    import lrr_pkg::*;

    localparam int EFF_CYCLES = (SELF_RST_CYCLES < 4) ? 4 : SELF_RST_CYCLES;
    localparam int CW         = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;

    logic          rst_n_int;
    logic          hit;
    logic          self_active;
    logic          busy;
    logic          self_start;
    logic [CW-1:0] run_cnt;
    top_state_t    st_q, st_d;

    lrr_rst_sync u_sync (
        .clk        (clk),
        .async_rst_n(hard_rst_n),
        .sync_rst_n (rst_n_int)
    );

    lrr_run_det #(.RUN_LEN(RUN_LEN), .CW(CW)) u_run (
        .clk      (clk),
        .rst_n    (rst_n_int),
        .hold_clr (busy),
        .sym_valid(sym_valid),
        .sym_type (sym_type),
        .pkt_start(pkt_start),
        .hit      (hit),
        .run_cnt  (run_cnt)
    );

    lrr_self_timer #(.CYCLES(EFF_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n_int),
        .start (self_start),
        .active(self_active)
    );

    assign busy       = self_active | st_q.pending;
    assign self_start = hit & cfg_self_rst_en;

    always_comb begin
        st_d = st_q;
        if (hit && !cfg_self_rst_en) begin
            st_d.pending = 1'b1;
        end else if (stat_clr && !self_active) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n_int) begin
        if (!rst_n_int) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_rst_n   = ~(self_active | st_q.pending);
    assign req_status = st_q.pending;
    assign irq        = st_q.pending & cfg_rst_int_en & rst_n_int & ~self_active;
endmodule

// File: rtl/lrr_checker.sv
module lrr_checker #(
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pkt_start,
    input logic          stat_clr,
    input logic          cfg_rst_int_en,
    input logic          irq,
    input logic          req_status,
    input logic          sw_rst_n,
    input logic          self_active,
    input logic [CW-1:0] run_cnt
);
    // R3: a packet start always clears the run
    assert_pkt_clears_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> (run_cnt == '0));

    // R4: a self reset lasts at least four cycles
    assert_self_min_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(self_active) |-> $past(self_active, 4));

    // R5: a latched request holds the reset output
    assert_latched_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_status |-> !sw_rst_n);

    // R5: a clear strobe on a latched request drops it
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_status && stat_clr) |=> !req_status);

    // R6: interrupt only with status and enable
    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (req_status && cfg_rst_int_en));

    // R7: no interrupt during hard reset
    assert_irq_quiet_hard_R7: assert property (@(posedge clk)
        !rst_n |-> !irq);

    // R7: no interrupt during self reset; the two modes never overlap
    assert_irq_quiet_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
        self_active |-> (!irq && $onehot0({self_active, req_status})));
endmodule

bind link_rst_req_ctrl lrr_checker #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .pkt_start     (pkt_start),
    .stat_clr      (stat_clr),
    .cfg_rst_int_en(cfg_rst_int_en),
    .irq           (irq),
    .req_status    (req_status),
    .sw_rst_n      (sw_rst_n),
    .self_active   (self_active),
    .run_cnt       (run_cnt)
);

// File: tb/link_rst_req_ctrl_tb.sv
`timescale 1ns/1ps
module link_rst_req_ctrl_tb;
    localparam int SELF_LEN = 6;

    logic       clk = 1'b0;
    logic       hard_rst_n;
    logic       sym_valid;
    logic [1:0] sym_type;
    logic       pkt_start;
    logic       cfg_self_rst_en;
    logic       cfg_rst_int_en;
    logic       stat_clr;
    logic       sw_rst_n;
    logic       req_status;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    link_rst_req_ctrl #(.RUN_LEN(4), .SELF_RST_CYCLES(SELF_LEN)) u_dut (
        .clk            (clk),
        .hard_rst_n     (hard_rst_n),
        .sym_valid      (sym_valid),
        .sym_type       (sym_type),
        .pkt_start      (pkt_start),
        .cfg_self_rst_en(cfg_self_rst_en),
        .cfg_rst_int_en (cfg_rst_int_en),
        .stat_clr       (stat_clr),
        .sw_rst_n       (sw_rst_n),
        .req_status     (req_status),
        .irq            (irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] t, input logic pkt = 1'b0);
        sym_valid = 1'b1;
        sym_type  = t;
        pkt_start = pkt;
        @(negedge clk);
        sym_valid = 1'b0;
        sym_type  = 2'd0;
        pkt_start = 1'b0;
    endtask

    task automatic send_rd(input int n);
        for (int i = 0; i < n; i++) send(2'd1);
    endtask

    task automatic pulse_clr();
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R10", "sw_rst_n after reset", sw_rst_n, 1);
        chk("R10", "req_status after reset", req_status, 0);
        chk("R10", "irq after reset", irq, 0);
    endtask

    task automatic t_threshold();
        cfg_self_rst_en = 1'b0;
        send_rd(3);
        chk("R1", "three symbols no request", req_status, 0);
        send(2'd2);
        send_rd(3);
        chk("R3", "other code breaks run", req_status, 0);
        send_rd(1);
        chk("R1", "fourth symbol recognised", req_status, 1);
        chk("R5", "sw_rst_n low on latch", sw_rst_n, 0);
        pulse_clr();
    endtask

    task automatic t_status_between();
        send_rd(1); send(2'd0); send_rd(1); send(2'd0); send(2'd0); send_rd(1);
        chk("R2", "status symbols keep run", req_status, 0);
        send_rd(1);
        chk("R2", "run completes across status", req_status, 1);
        pulse_clr();
    endtask

    task automatic t_packet_break();
        send_rd(2);
        pkt_start = 1'b1; @(negedge clk); pkt_start = 1'b0;
        send_rd(2);
        chk("R3", "packet clears run", req_status, 0);
        send_rd(2);
        chk("R3", "fresh run after packet", req_status, 1);
        pulse_clr();
        send_rd(3);
        send(2'd1, 1'b1);
        send_rd(3);
        chk("R3", "packet beats colliding symbol", req_status, 0);
        send_rd(1);
        chk("R3", "run after collision", req_status, 1);
        pulse_clr();
    endtask

    task automatic t_latched();
        cfg_rst_int_en = 1'b1;
        send_rd(4);
        chk("R5", "status set", req_status, 1);
        chk("R6", "irq with enable", irq, 1);
        repeat (5) @(negedge clk);
        chk("R5", "sw_rst_n still held", sw_rst_n, 0);
        send_rd(4);
        chk("R9", "extra symbols keep status", req_status, 1);
        pulse_clr();
        chk("R5", "status cleared", req_status, 0);
        chk("R5", "sw_rst_n released", sw_rst_n, 1);
        chk("R6", "irq drops with status", irq, 0);
        send_rd(1);
        chk("R9", "pending symbols not counted", req_status, 0);
        cfg_rst_int_en = 1'b0;
        send_rd(3);
        chk("R6", "status without enable", req_status, 1);
        chk("R6", "irq masked", irq, 0);
        pulse_clr();
    endtask

    task automatic t_self(input bool_noise);
        int n = 0;
        int bad_irq = 0;
        int bad_stat = 0;
        cfg_self_rst_en = 1'b1;
        cfg_rst_int_en  = 1'b1;
        send_rd(4);
        while (!sw_rst_n && n < 100) begin
            n++;
            if (irq) bad_irq++;
            if (req_status) bad_stat++;
            if (bool_noise) begin
                stat_clr  = 1'b1;
                sym_valid = 1'b1;
                sym_type  = 2'd1;
            end
            @(negedge clk);
        end
        stat_clr  = 1'b0;
        sym_valid = 1'b0;
        sym_type  = 2'd0;
        if (bool_noise) begin
            chk("R8", "duration with clear strobes", n, SELF_LEN);
            chk("R9", "duration with extra symbols", n, SELF_LEN);
        end else begin
            chk("R4", "self reset duration", n, SELF_LEN);
            chk("R4", "no status in self reset", bad_stat, 0);
        end
        chk("R7", "no irq in self reset", bad_irq, 0);
        send_rd(3);
        chk("R4", "run idle after self reset", sw_rst_n, 1);
        send(2'd2);
        cfg_self_rst_en = 1'b0;
    endtask

    task automatic t_hard();
        cfg_rst_int_en = 1'b1;
        send_rd(4);
        chk("R6", "irq before hard reset", irq, 1);
        #2 hard_rst_n = 1'b0;
        #1;
        chk("R10", "status cleared async", req_status, 0);
        chk("R10", "sw_rst_n high in hard reset", sw_rst_n, 1);
        chk("R7", "irq low in hard reset", irq, 0);
        @(negedge clk);
        send_rd(4);
        chk("R7", "irq stays low in hard reset", irq, 0);
        hard_rst_n = 1'b1;
        @(negedge clk);
        send_rd(1);
        send_rd(3);
        chk("R10", "symbols before second edge lost", req_status, 0);
        send_rd(1);
        chk("R10", "counting resumes after release", req_status, 1);
        pulse_clr();
        send_rd(3);
        hard_rst_n = 1'b0;
        @(negedge clk);
        hard_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        send_rd(1);
        chk("R10", "partial run lost", req_status, 0);
        send_rd(3);
        pulse_clr();
    endtask

    initial begin
        hard_rst_n      = 1'b0;
        sym_valid       = 1'b0;
        sym_type        = 2'd0;
        pkt_start       = 1'b0;
        cfg_self_rst_en = 1'b0;
        cfg_rst_int_en  = 1'b0;
        stat_clr        = 1'b0;
        repeat (3) @(negedge clk);
        hard_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_threshold();
        t_status_between();
        t_packet_break();
        t_latched();
        t_self(1'b0);
        t_self(1'b1);
        t_hard();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule